// File: doc/BRIEF.md
# Extended-Superframe Bit-Oriented Code Detector

This block watches the serial data-link bit stream carried in the extended superframe of a T1 line and picks out 16-bit bit-oriented code words. Each incoming link bit arrives with a qualifying strobe. Every qualified bit enters a 16-bit shift window, and the window is tested against the code-word framing on every bit. Code words are therefore found at any bit alignment.

A code is reported only after it has been seen in two back-to-back code words. On confirmation the six code bits are latched into a code register and a sticky flag is raised for the host. A host read clears the flag and returns the code register to all ones. The read also discards any confirmation in progress. The all-ones code cannot be told apart from idle flags, so it is never reported.

Top module: `boc_detect`

## Requirements
- R1: After reset `flag` is 0 and `code_q[5:0]` is 6'h3F.
- R2: `code_q[7:6]` always reads 0.
- R3: A code word, in arrival order, is a 0, then code bits X5 down to X0, then a 0, then eight 1s. It is recognized at the qualified bit that completes it, whatever its alignment to earlier bits.
- R4: The latched code holds X0 in `code_q[0]` through X5 in `code_q[5]`.
- R5: A code is confirmed when a code word with the same six bits completes exactly 16 qualified bits after the previous one. A single extra qualified bit between the two words prevents confirmation. On confirmation, `flag` and `code_q` update at the clock edge that takes the last bit of the second word.
- R6: A single code word never sets `flag`. A word carrying a different code restarts confirmation, so that code is confirmed by the next back-to-back word with the same value.
- R7: A code word whose six code bits are all 1 is never recognized and never sets `flag`.
- R8: A cycle with `rd_stb` high clears `flag` to 0 and sets `code_q[5:0]` to 6'h3F at the next edge. It also discards confirmation history, so two further code words are needed before the flag sets again. The read takes priority over a bit in the same cycle, although that bit still enters the window.
- R9: While `flag` is 1, further confirmations change neither `code_q` nor `flag`.
- R10: A cycle with `bit_valid` low has no effect on detection, whatever `bit_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Data-link bit |
| rd_stb | input | 1 | Host read of code/status; clear-on-read |
| code_q | output | 8 | Latched code; bits 7:6 are zero |
| flag | output | 1 | Sticky code-detected flag |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- Code bit order. The code 0x0B is asymmetric, so a reversed capture would latch 0x34.
- Spacing between words. A one-bit gap between two matching words must not confirm; a design counting any two matches would raise the flag.
- All-ones code. This code must be rejected; a design without the exclusion would report 0x3F as a code.
- Interaction with host reads. A read must clear the history as well as the status, so one word right after a read must not re-raise the flag.
- Later confirmations. While the flag is set, a new confirmation must not overwrite the held code.
- Unqualified and random bits. Junk on unqualified cycles and random streams are compared bit by bit against a bench model. This exposes misalignment and spurious matches.

// File: rtl/boc_detect.sv
module boc_detect #(
  parameter int CW   = 6,
  parameter int FILL = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       rd_stb,
  output logic [7:0] code_q,
  output logic       flag
);
  localparam int MLEN = CW + 2 + FILL;
  localparam int GAPW = $clog2(MLEN) + 1;
  localparam logic [GAPW-1:0] GAP_MAX = '1;
  localparam logic [GAPW-1:0] GAP_HIT = GAPW'(MLEN - 1);
  localparam logic [CW-1:0] ONES = '1;

  logic [MLEN-1:0] win;
  logic [MLEN-1:0] win_nxt;
  logic [GAPW-1:0] gap;
  logic [CW-1:0]   cand;
  logic [CW-1:0]   code_r;
  logic [CW-1:0]   hit_code;
  logic            hit;
  logic            confirm;

  assign win_nxt  = {win[MLEN-2:0], bit_in};
  assign hit_code = win_nxt[MLEN-2 -: CW];
  assign hit      = !win_nxt[MLEN-1] && !win_nxt[FILL] && (&win_nxt[FILL-1:0])
                    && (hit_code != ONES);
  assign confirm  = hit && (gap == GAP_HIT) && (hit_code == cand);
  assign code_q   = {{(8-CW){1'b0}}, code_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win    <= '1;
      gap    <= GAP_MAX;
      cand   <= ONES;
      code_r <= ONES;
      flag   <= 1'b0;
    end else begin
      if (bit_valid) win <= win_nxt;
      if (rd_stb) begin
        flag   <= 1'b0;
        code_r <= ONES;
        gap    <= GAP_MAX;
      end else if (bit_valid) begin
        if (hit) begin
          gap  <= '0;
          cand <= hit_code;
          if (confirm && !flag) begin
            flag   <= 1'b1;
            code_r <= hit_code;
          end
        end else if (gap != GAP_MAX) begin
          gap <= gap + 1'b1;
        end
      end
    end
  end

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (!flag && code_r == ONES));
  assert_no_ones_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (code_r != ONES));
  assert_set_on_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(bit_valid));
  assert_hold_while_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rd_stb) |=> $stable(code_r));
  assert_idle_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(win));
endmodule

// File: tb/test_boc_detect.sv
module test_boc_detect;
  logic clk = 0, rst_n = 0, bit_valid = 0, bit_in = 0, rd_stb = 0;
  logic [7:0] code_q;
  logic flag;
  int nvec = 0, nerr = 0;
  bit done = 0;

  logic [15:0] m_win;
  int          m_gap;
  logic [5:0]  m_cand, m_code;
  logic        m_flag;

  boc_detect i_boc_detect (.clk, .rst_n, .bit_valid, .bit_in, .rd_stb, .code_q, .flag);

  always #5 clk = ~clk;

  function automatic logic is_word(logic [15:0] w);
    return !w[15] && !w[8] && w[7:0] == 8'hFF && w[14:9] != 6'h3F;
  endfunction

  function automatic logic [15:0] frame(logic [5:0] c);
    return {1'b0, c, 1'b0, 8'hFF};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step(logic v, logic b, logic rd);
    logic [15:0] n;
    n = {m_win[14:0], b};
    if (v) m_win = n;
    if (rd) begin
      m_flag = 0; m_code = 6'h3F; m_gap = 99;
    end else if (v) begin
      if (is_word(n)) begin
        if (m_gap == 15 && n[14:9] == m_cand && !m_flag) begin
          m_flag = 1; m_code = n[14:9];
        end
        m_gap = 0; m_cand = n[14:9];
      end else if (m_gap < 99) m_gap++;
    end
  endtask

  task automatic cycle(logic v, logic b, logic rd);
    @(negedge clk);
    bit_valid = v; bit_in = b; rd_stb = rd;
    @(negedge clk);
    bit_valid = 0; rd_stb = 0; bit_in = $urandom;
    model_step(v, b, rd);
    chk("R3 model", code_q, {2'b00, m_code});
    chk("R3 model flag", {7'd0, flag}, {7'd0, m_flag});
  endtask

  task automatic send_word(logic [5:0] c);
    logic [15:0] f;
    f = frame(c);
    for (int i = 15; i >= 0; i--) cycle(1, f[i], 0);
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_win = '1; m_gap = 99; m_cand = 6'h3F; m_code = 6'h3F; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag", {7'd0, flag}, 8'd0);
    chk("R1 code", code_q, 8'h3F);
    chk("R2 reserved", {6'd0, code_q[7:6]}, 8'd0);

    send_word(6'h0B);
    chk("R6 single word", {7'd0, flag}, 8'd0);
    send_word(6'h0B);
    chk("R5 confirm", {7'd0, flag}, 8'd1);
    chk("R4 bit order", code_q, 8'h0B);

    send_word(6'h15); send_word(6'h15);
    chk("R9 held code", code_q, 8'h0B);

    cycle(0, 0, 1);
    chk("R8 flag cleared", {7'd0, flag}, 8'd0);
    chk("R8 code cleared", code_q, 8'h3F);
    send_word(6'h15);
    chk("R8 history dropped", {7'd0, flag}, 8'd0);

    cycle(0, 0, 1);
    send_word(6'h3F); send_word(6'h3F); send_word(6'h3F);
    chk("R7 ones rejected", {7'd0, flag}, 8'd0);

    send_word(6'h22); send_word(6'h05);
    chk("R6 restart", {7'd0, flag}, 8'd0);
    send_word(6'h05);
    chk("R6 new code", code_q, 8'h05);

    cycle(0, 0, 1);
    send_word(6'h2A); cycle(1, 1, 0); send_word(6'h2A);
    chk("R5 gap blocks", {7'd0, flag}, 8'd0);
    send_word(6'h2A);
    chk("R5 after gap", code_q, 8'h2A);

    cycle(0, 0, 1);
    for (int k = 0; k < 2; k++) begin
      logic [15:0] f;
      f = frame(6'h11);
      for (int i = 15; i >= 0; i--) begin
        cycle(0, 0, 0);
        cycle(1, f[i], 0);
      end
    end
    chk("R10 idle ignored", code_q, 8'h11);
    chk("R2 reserved", {6'd0, code_q[7:6]}, 8'd0);

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) cycle(0, 0, 1);
      else if (r < 10) send_word(6'($urandom_range(0, 63)));
      else if (r < 20) cycle(0, 1'($urandom), 0);
      else if (r < 60) cycle(1, 1, 0);
      else cycle(1, 1'($urandom), 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule